// File: doc/BRIEF.md
# Host Data-Request Byte Transfer Controller

This block sends a block of bytes from a buffer to a host. It uses a request/strobe handshake of the kind a simple DMA engine uses. A control processor writes a byte count and a buffer start pointer through a small register port, then issues a start command. The block raises a data request. The host answers with a read pulse, and the block places the byte at the current pointer on the host data bus and advances the pointer. The request drops while the pulse is high and returns once the pulse ends, for as long as bytes remain.

During the read pulse of the last byte, the block raises an end-of-process strobe. When that pulse ends, the data-enable status goes inactive and an active-low completion interrupt is raised toward the control processor. The interrupt stays low until the processor writes an acknowledge command. Status is reported in a packed interface-status byte. The high count register also has a read view, in which the interrupt flag appears in its upper nibble.

The buffer is modelled as a synchronous read port: the data for an address appears one clock after the address is presented.

Top module: `host_drq_xfer`

## Requirements
- R1: After reset, `drq` and `eop` are low, `xfer_irq_n` is high, `if_status` reads 0xFF and `cnt_hi_rd` reads 0xF0.
- R2: Processor writes (`cpu_we` high) decode `cpu_addr` as follows: 0 is count bits 7..0, 1 is count bits 11..8 taken from `cpu_wdata[3:0]`, 2 is pointer low byte, 3 is pointer high byte, and 4 is the command register (bit0 start, bit1 acknowledge). `cnt_hi_rd` returns count bits 11..8 in bits 3..0 and the interrupt flag copied into bits 7..4.
- R3: `if_status` bits are, from bit 7 down: command flag, completion interrupt flag, decoder flag, constant 1, data-busy, status-busy, data-enable, status-enable. All are active-low, and command, decoder, status-busy and status-enable stay 1. Data-busy and data-enable go low in the cycle after a start write, and `drq` rises one cycle later.
- R4: `drq` falls in the cycle after `host_rd` is seen high while requested. It rises again two cycles after `host_rd` falls if bytes remain.
- R5: Each accepted read puts on `host_data` the buffer byte at the current pointer, and the pointer then increments by one, wrapping from 0xFFFF to 0x0000.
- R6: `eop` is high while `host_rd` is high during the read of the final byte, and at no other time.
- R7: When the final read pulse ends, data-enable returns to 1 and the interrupt flag and `xfer_irq_n` go low. Data-busy is already back at 1 from the final acceptance. `drq` stays low.
- R8: A command write with bit1 set returns the interrupt flag and `xfer_irq_n` to 1.
- R9: A programmed count of zero transfers 4096 bytes.
- R10: While a transfer is in progress, a start command and writes to the count and pointer registers are ignored.
- R11: A read pulse while `drq` is low leaves `host_data` and the remaining count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Processor register write strobe |
| cpu_addr | input | 3 | Processor register address |
| cpu_wdata | input | 8 | Processor write data |
| host_rd | input | 1 | Host read pulse, active high |
| drq | output | 1 | Data request to host |
| eop | output | 1 | End-of-process strobe |
| host_data | output | 8 | Byte returned to host |
| buf_addr | output | 16 | Buffer read address (current pointer) |
| buf_rdata | input | 8 | Buffer read data, one cycle after address |
| if_status | output | 8 | Packed interface-status byte |
| cnt_hi_rd | output | 8 | Read view of the high count register |
| xfer_irq_n | output | 1 | Transfer-complete interrupt, active low |

## Verification
The main transfer path is driven with four patterns, each chosen to expose a different fault:
- A short five-byte run separates per-byte data and pointer errors from errors in end-of-process placement.
- A 259-byte run starting near the top of the address space checks that the high count nibble is used and that the pointer wraps.
- A zero count must produce exactly 4096 bytes, with the strobe on the last one only. This tells a count treated as 4096 apart from one treated as empty or truncated.
- A run interrupted by a second start and stray register writes shows whether busy-time writes disturb the pointer or the count.

Stray read pulses while idle separate correct request gating from data that follows every pulse.

// File: rtl/host_drq_pkg.sv
package host_drq_pkg;
  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_FETCH = 2'd1,
    XS_REQ   = 2'd2,
    XS_ACT   = 2'd3
  } xfer_state_e;

  localparam logic [2:0] RA_CNT_LO = 3'd0;
  localparam logic [2:0] RA_CNT_HI = 3'd1;
  localparam logic [2:0] RA_PTR_LO = 3'd2;
  localparam logic [2:0] RA_PTR_HI = 3'd3;
  localparam logic [2:0] RA_CMD    = 3'd4;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_ACK_BIT   = 1;
endpackage

// File: rtl/drq_cfg_regs.sv
module drq_cfg_regs
  import host_drq_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              busy,
  input  logic              ptr_inc,
  output logic [CNT_W-1:0]  cnt_prog,
  output logic [ADDR_W-1:0] ptr,
  output logic              start_cmd,
  output logic              ack_cmd
);
  localparam int CNT_HI_W = CNT_W - 8;
  localparam int PTR_HI_W = ADDR_W - 8;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    cnt_d = cnt_q;
    ptr_d = ptr_q;
    if (ptr_inc) begin
      ptr_d = ptr_q + 1'b1;
    end else if (cpu_we && !busy) begin
      case (cpu_addr)
        RA_CNT_LO: cnt_d[7:0]       = cpu_wdata;
        RA_CNT_HI: cnt_d[CNT_W-1:8] = cpu_wdata[CNT_HI_W-1:0];
        RA_PTR_LO: ptr_d[7:0]       = cpu_wdata;
        RA_PTR_HI: ptr_d[ADDR_W-1:8] = cpu_wdata[PTR_HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ptr_q <= ptr_d;
    end
  end

  assign cnt_prog  = cnt_q;
  assign ptr       = ptr_q;
  assign start_cmd = cpu_we && (cpu_addr == RA_CMD) && cpu_wdata[CMD_START_BIT];
  assign ack_cmd   = cpu_we && (cpu_addr == RA_CMD) && cpu_wdata[CMD_ACK_BIT];

  // R10
  cfg_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ptr_inc) |=> (ptr_q == $past(ptr_q)) && (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/drq_xfer_fsm.sv
module drq_xfer_fsm
  import host_drq_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cmd,
  input  logic [CNT_W-1:0]  cnt_prog,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              drq,
  output logic              eop,
  output logic              busy,
  output logic              start_ok,
  output logic              accept,
  output logic              final_accept,
  output logic              finish,
  output logic [DATA_W-1:0] host_data
);
  localparam int LEFT_W = CNT_W + 1;
  localparam logic [LEFT_W-1:0] LEFT_ONE = LEFT_W'(1);

  xfer_state_e       state_q, state_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              last_q, last_d;

  assign busy         = (state_q != XS_IDLE);
  assign start_ok     = start_cmd && (state_q == XS_IDLE);
  assign accept       = (state_q == XS_REQ) && host_rd;
  assign final_accept = accept && (left_q == LEFT_ONE);
  assign finish       = (state_q == XS_ACT) && !host_rd && last_q;

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    data_d  = data_q;
    last_d  = last_q;
    case (state_q)
      XS_IDLE: begin
        if (start_cmd) begin
          state_d = XS_FETCH;
          left_d  = {(cnt_prog == '0), cnt_prog};
          last_d  = 1'b0;
        end
      end
      XS_FETCH: state_d = XS_REQ;
      XS_REQ: begin
        if (host_rd) begin
          state_d = XS_ACT;
          left_d  = left_q - LEFT_ONE;
          data_d  = buf_rdata;
          last_d  = (left_q == LEFT_ONE);
        end
      end
      XS_ACT: begin
        if (!host_rd) state_d = last_q ? XS_IDLE : XS_FETCH;
      end
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      left_q  <= '0;
      data_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      data_q  <= data_d;
      last_q  <= last_d;
    end
  end

  assign drq       = (state_q == XS_REQ);
  assign eop       = host_rd && (((state_q == XS_REQ) && (left_q == LEFT_ONE)) ||
                                 ((state_q == XS_ACT) && last_q));
  assign host_data = data_q;

  // R4
  drq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && host_rd) |=> !drq);
  // R9
  no_empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drq |-> (left_q != '0));
  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_cmd && !accept) |=> (left_q == $past(left_q)));
  // R11
  stray_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drq && host_rd) |=> $stable(host_data));
endmodule

// File: rtl/drq_status.sv
module drq_status #(
  parameter int CNT_HI_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_ok,
  input  logic                final_accept,
  input  logic                finish,
  input  logic                ack_cmd,
  input  logic [CNT_HI_W-1:0] cnt_hi,
  output logic [7:0]          if_status,
  output logic [7:0]          cnt_hi_rd,
  output logic                xfer_irq_n
);
  localparam int FLAG_REP = 8 - CNT_HI_W;

  logic dtbsy_q, dtbsy_d;
  logic dten_q,  dten_d;
  logic dtei_q,  dtei_d;

  always_comb begin
    dtbsy_d = dtbsy_q;
    dten_d  = dten_q;
    dtei_d  = dtei_q;
    if (start_ok) begin
      dtbsy_d = 1'b0;
      dten_d  = 1'b0;
    end
    if (final_accept) dtbsy_d = 1'b1;
    if (ack_cmd)      dtei_d  = 1'b1;
    if (finish) begin
      dten_d = 1'b1;
      dtei_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtbsy_q <= 1'b1;
      dten_q  <= 1'b1;
      dtei_q  <= 1'b1;
    end else begin
      dtbsy_q <= dtbsy_d;
      dten_q  <= dten_d;
      dtei_q  <= dtei_d;
    end
  end

  assign if_status  = {1'b1, dtei_q, 1'b1, 1'b1, dtbsy_q, 1'b1, dten_q, 1'b1};
  assign cnt_hi_rd  = {{FLAG_REP{dtei_q}}, cnt_hi};
  assign xfer_irq_n = dtei_q;

  // R7
  irq_at_dten_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dten_q) |-> !dtei_q);
  // R3
  busy_within_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dtbsy_q |-> !dten_q);
endmodule

// File: rtl/host_drq_xfer.sv
module host_drq_xfer #(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              host_rd,
  output logic              drq,
  output logic              eop,
  output logic [DATA_W-1:0] host_data,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic [7:0]        if_status,
  output logic [7:0]        cnt_hi_rd,
  output logic              xfer_irq_n
);
  localparam int CNT_HI_W = CNT_W - 8;

  logic [CNT_W-1:0] cnt_prog;
  logic             start_cmd, ack_cmd;
  logic             busy, start_ok, accept, final_accept, finish;

  drq_cfg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .busy      (busy),
    .ptr_inc   (accept),
    .cnt_prog  (cnt_prog),
    .ptr       (buf_addr),
    .start_cmd (start_cmd),
    .ack_cmd   (ack_cmd)
  );

  drq_xfer_fsm #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_cmd    (start_cmd),
    .cnt_prog     (cnt_prog),
    .host_rd      (host_rd),
    .buf_rdata    (buf_rdata),
    .drq          (drq),
    .eop          (eop),
    .busy         (busy),
    .start_ok     (start_ok),
    .accept       (accept),
    .final_accept (final_accept),
    .finish       (finish),
    .host_data    (host_data)
  );

  drq_status #(.CNT_HI_W(CNT_HI_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_ok     (start_ok),
    .final_accept (final_accept),
    .finish       (finish),
    .ack_cmd      (ack_cmd),
    .cnt_hi       (cnt_prog[CNT_W-1:8]),
    .if_status    (if_status),
    .cnt_hi_rd    (cnt_hi_rd),
    .xfer_irq_n   (xfer_irq_n)
  );

  // R6
  eop_in_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> (host_rd && !if_status[1]));
endmodule

// File: tb/host_drq_xfer_tb_top.sv
`timescale 1ns/1ps
module host_drq_xfer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_we;
  logic [2:0]  cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        host_rd;
  logic        drq, eop, xfer_irq_n;
  logic [7:0]  host_data, buf_rdata, if_status, cnt_hi_rd;
  logic [15:0] buf_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  event byte_ev;

  always #4 clk = ~clk;

  host_drq_xfer dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .host_rd(host_rd), .drq(drq), .eop(eop),
    .host_data(host_data), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .if_status(if_status), .cnt_hi_rd(cnt_hi_rd), .xfer_irq_n(xfer_irq_n)
  );

  function automatic logic [7:0] fmem(input logic [15:0] a);
    return (a[7:0] + 8'h3C) ^ a[15:8];
  endfunction

  always @(posedge clk) buf_rdata <= fmem(buf_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // monitor: pops the expected byte for every completed host read
  initial begin
    forever begin
      @(byte_ev);
      if (exp_q.size() == 0) chk("R5 unexpected byte", host_data, 32'hFFFF);
      else chk("R5 byte", host_data, exp_q.pop_front());
    end
  end

  task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  // driver: programs a transfer and pushes its expected bytes
  task automatic start_xfer(input logic [11:0] cnt, input logic [15:0] p);
    int n;
    cpu_write(3'd0, cnt[7:0]);
    cpu_write(3'd1, {4'h0, cnt[11:8]});
    cpu_write(3'd2, p[7:0]);
    cpu_write(3'd3, p[15:8]);
    n = (cnt == 0) ? 4096 : int'(cnt);
    for (int i = 0; i < n; i++) exp_q.push_back(fmem(p + 16'(i)));
    cpu_write(3'd4, 8'h01);
  endtask

  task automatic host_read(input bit last);
    while (!drq) @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    -> byte_ev;
    chk("R6 eop during pulse", eop, last);
    chk("R4 drq low in pulse", drq, 1'b0);
    host_rd = 1'b0;
    @(negedge clk);
    chk("R6 eop after pulse", eop, 1'b0);
    chk("R4 drq low after pulse", drq, 1'b0);
    if (!last) begin
      @(negedge clk);
      chk("R4 drq back", drq, 1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    rst_n = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; host_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 drq", drq, 1'b0);
    chk("R1 eop", eop, 1'b0);
    chk("R1 irq", xfer_irq_n, 1'b1);
    chk("R1 status", if_status, 8'hFF);
    chk("R1 cnt_hi_rd", cnt_hi_rd, 8'hF0);

    // R3: short transfer
    start_xfer(12'd5, 16'h1234);
    chk("R3 status at start", if_status, 8'hF5);
    chk("R3 drq not yet", drq, 1'b0);
    @(negedge clk);
    chk("R3 drq raised", drq, 1'b1);
    for (int i = 0; i < 5; i++) host_read(i == 4);
    // R7
    chk("R7 status done", if_status, 8'hBF);
    chk("R7 irq", xfer_irq_n, 1'b0);
    chk("R2 cnt_hi_rd flag", cnt_hi_rd, 8'h00);
    repeat (3) @(negedge clk);
    chk("R7 drq stays low", drq, 1'b0);
    // R8
    cpu_write(3'd4, 8'h02);
    chk("R8 status cleared", if_status, 8'hFF);
    chk("R8 irq cleared", xfer_irq_n, 1'b1);

    // R11: stray pulse while idle
    held = host_data;
    host_rd = 1'b1;
    repeat (2) @(negedge clk);
    host_rd = 1'b0;
    @(negedge clk);
    chk("R11 data held", host_data, held);
    chk("R11 no request", drq, 1'b0);
    chk("R11 status", if_status, 8'hFF);

    // R2 / R5: high nibble and pointer wrap
    start_xfer(12'h103, 16'hFFF0);
    chk("R2 cnt_hi_rd nibble", cnt_hi_rd, 8'hF1);
    for (int i = 0; i < 259; i++) host_read(i == 258);
    chk("R7 status 259", if_status, 8'hBF);
    cpu_write(3'd4, 8'h02);

    // R10: start and register writes during a transfer
    start_xfer(12'd4, 16'h0100);
    host_read(1'b0);
    host_read(1'b0);
    cpu_write(3'd4, 8'h01);
    cpu_write(3'd2, 8'h55);
    cpu_write(3'd0, 8'h09);
    chk("R10 still busy", if_status, 8'hF5);
    host_read(1'b0);
    host_read(1'b1);
    repeat (3) @(negedge clk);
    chk("R10 no restart", drq, 1'b0);
    chk("R10 status done", if_status, 8'hBF);
    cpu_write(3'd4, 8'h02);

    // R9: zero count means 4096
    start_xfer(12'd0, 16'h8000);
    for (int i = 0; i < 4096; i++) host_read(i == 4095);
    chk("R9 done after 4096", if_status, 8'hBF);
    chk("R9 irq", xfer_irq_n, 1'b0);
    cpu_write(3'd4, 8'h02);

    repeat (2) @(negedge clk);
    chk("R5 all bytes seen", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule